// File: doc/BRIEF.md
# Counter Snapshot Capture Unit

This block lets software read a pair of free-running 8-bit counters safely. The two counters form one 16-bit value. When a capture event occurs, the block copies both counter bytes into a 16-bit shadow register on a single clock edge. A reader therefore never sees a low byte from one moment paired with a high byte from another.

The capture event comes from one of four sources. Two are single-cycle tick pulses from a prescaler. The other two are asynchronous external pins, which are synchronized first and then watched for rising edges. While capture is enabled, the read port shows the shadow register. While it is disabled, the read port shows the live counters directly. Each capture raises a one-cycle interrupt pulse for an interrupt controller placed outside this block.

Top module: `capture_snapshot_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the shadow register clears to zero and `cap_irq` goes low.
- R2: `rd_data` equals `{cnt_hi, cnt_lo}` while `cap_en` is 0, and equals the shadow register while `cap_en` is 1, combinationally.
- R3: Source select encoding: 0 is `tick[0]`, 1 is `tick[1]`, 2 is `ext_pin[0]` and 3 is `ext_pin[1]`. With `cap_en` high and a selected tick high at a clock edge, the shadow takes `{cnt_hi, cnt_lo}` sampled at that same edge.
- R4: Sources that are not selected never cause a capture or an interrupt.
- R5: An external pin capture fires on a rising edge only. After the pin goes high, the shadow updates on the third rising clock edge, with the counter values present at that edge. A pin held high causes exactly one capture.
- R6: `cap_irq` is high for exactly the one cycle that follows each shadow update, and it is low in every other cycle.
- R7: While `cap_en` is low, the shadow register keeps its value and `cap_irq` stays low. A pin edge that occurs while `cap_en` is low is not captured later, after the block is enabled.
- R8: The high byte of the shadow (bits 15:8, from `cnt_hi`) and the low byte (bits 7:0, from `cnt_lo`) always come from the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Enables capture and selects the shadow register for reads |
| src_sel | input | 2 | Capture source: 0 and 1 are ticks, 2 and 3 are external pins |
| cnt_lo | input | 8 | Live value of the low counter |
| cnt_hi | input | 8 | Live value of the high counter |
| tick | input | 2 | Single-cycle tick pulses from the prescaler |
| ext_pin | input | 2 | Asynchronous external capture pins |
| shadow | output | 16 | Captured snapshot, `{cnt_hi, cnt_lo}` |
| rd_data | output | 16 | Read data: the shadow register or the live counters |
| cap_irq | output | 1 | One-cycle pulse after each capture |

## Verification
Random tick patterns are run against counters that change every cycle. Because both bytes change each cycle, a capture taken one edge early or late shows up as a wrong byte, and so does a torn byte pair. Random tick patterns also include ticks on the source that is not selected, which separates correct source selection from capture on any tick. Directed pin sequences change the counter value before each of the three edges of the synchronizer window, so a capture in the wrong cycle returns the wrong value. A held pin level, a pin edge that occurs while capture is disabled, and a rising edge on the pin that is not selected each check that only a fresh rising edge on the chosen pin causes a capture.

// File: rtl/cap_pkg.sv
// Shared constants for the counter snapshot capture unit.
// Assumes the tick sources sit below the pin sources in select order.
package cap_pkg;

    // Default geometry of the capture unit
    localparam int CAP_CNT_W      = 8;
    localparam int CAP_N_TICK     = 2;
    localparam int CAP_N_PIN      = 2;
    localparam int CAP_SYNC_DEPTH = 2;

    // Select width for a given number of sources (at least one bit)
    function automatic int sel_width(input int n_src);
        return (n_src > 1) ? $clog2(n_src) : 1;
    endfunction

endpackage

// File: rtl/cap_pin_sync.sv
// Synchronizes asynchronous capture pins and flags their rising edges.
// Each pin goes through SYNC_DEPTH flops. A one-cycle pulse marks a
// low-to-high change at the synchronizer output.
// Assumes SYNC_DEPTH >= 2 and that pins are low while reset is applied.
module cap_pin_sync #(
    parameter int N_PIN      = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_async,
    output logic [N_PIN-1:0] pin_rise
);

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        logic [SYNC_DEPTH-1:0] chain_q;
        logic                  last_q;

        // Shift the pin through the synchronizer and keep the previous output
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                last_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[SYNC_DEPTH-2:0], pin_async[p]};
                last_q  <= chain_q[SYNC_DEPTH-1];
            end
        end

        // Rising edge at the synchronizer output
        always_comb begin
            pin_rise[p] = chain_q[SYNC_DEPTH-1] & ~last_q;
        end

        // R5
        rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pin_rise[p] |=> !pin_rise[p])
            else $error("pin edge pulse wider than one cycle");
    end

endmodule

// File: rtl/cap_event_sel.sv
// Picks one capture source out of the tick pulses and pin edges, and
// gates it with the enable. Select values below N_TICK choose a tick.
// The next N_PIN values choose a pin edge. Any higher value never fires.
module cap_event_sel #(
    parameter int N_TICK = 2,
    parameter int N_PIN  = 2,
    parameter int SRC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic [N_TICK-1:0] tick,
    input  logic [N_PIN-1:0]  pin_rise,
    output logic              cap_evt
);

    localparam int N_SRC = N_TICK + N_PIN;

    logic [N_SRC-1:0] src_vec;
    logic             sel_ok;

    // Merge all sources into one vector and decode the select
    always_comb begin
        src_vec = {pin_rise, tick};
        sel_ok  = ({1'b0, src_sel} < (SRC_W+1)'(N_SRC));
        cap_evt = cap_en && sel_ok && src_vec[src_sel];
    end

    // R4
    evt_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> ((tick != '0) || (pin_rise != '0)))
        else $error("capture event without any source active");

endmodule

// File: rtl/cap_shadow.sv
// Holds the 16-bit snapshot. Both counter bytes are written on the edge
// where the event is high, and a one-cycle interrupt is raised together
// with the new contents.
module cap_shadow #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_evt,
    input  logic [CNT_W-1:0]   cnt_lo,
    input  logic [CNT_W-1:0]   cnt_hi,
    output logic [2*CNT_W-1:0] shadow_q,
    output logic               irq_q
);

    // Latch both bytes on the same edge and flag the update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= cap_evt;
            if (cap_evt) begin
                shadow_q <= {cnt_hi, cnt_lo};
            end
        end
    end

    // R6
    shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> (shadow_q == $past(shadow_q)))
        else $error("shadow changed without interrupt");

    // R8
    snapshot_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (shadow_q == $past({cnt_hi, cnt_lo})))
        else $error("snapshot bytes not from one edge");

endmodule

// File: rtl/capture_snapshot_unit.sv
// Top of the counter snapshot capture unit. It ties together the pin
// synchronizers, the source selector and the shadow register, and it
// steers the read port between the shadow and the live counters.
// Assumes the tick inputs are synchronous to clk.
module capture_snapshot_unit #(
    parameter int CNT_W      = cap_pkg::CAP_CNT_W,
    parameter int N_TICK     = cap_pkg::CAP_N_TICK,
    parameter int N_PIN      = cap_pkg::CAP_N_PIN,
    parameter int SYNC_DEPTH = cap_pkg::CAP_SYNC_DEPTH,
    parameter int SRC_W      = cap_pkg::sel_width(N_TICK + N_PIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [CNT_W-1:0]   cnt_lo,
    input  logic [CNT_W-1:0]   cnt_hi,
    input  logic [N_TICK-1:0]  tick,
    input  logic [N_PIN-1:0]   ext_pin,
    output logic [2*CNT_W-1:0] shadow,
    output logic [2*CNT_W-1:0] rd_data,
    output logic               cap_irq
);

    localparam int SNAP_W = 2 * CNT_W;

    logic [N_PIN-1:0]  pin_rise;
    logic              cap_evt;
    logic [SNAP_W-1:0] shadow_q;
    logic              irq_q;

    cap_pin_sync #(
        .N_PIN      (N_PIN),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .pin_rise  (pin_rise)
    );

    cap_event_sel #(
        .N_TICK (N_TICK),
        .N_PIN  (N_PIN),
        .SRC_W  (SRC_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .src_sel  (src_sel),
        .tick     (tick),
        .pin_rise (pin_rise),
        .cap_evt  (cap_evt)
    );

    cap_shadow #(
        .CNT_W (CNT_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_evt  (cap_evt),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .shadow_q (shadow_q),
        .irq_q    (irq_q)
    );

    // Drive outputs and steer reads between the snapshot and the live counters
    always_comb begin
        shadow  = shadow_q;
        cap_irq = irq_q;
        rd_data = cap_en ? shadow_q : {cnt_hi, cnt_lo};
    end

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> !cap_irq)
        else $error("interrupt while capture disabled");

endmodule

// File: tb/tb_capture_snapshot_unit.sv
module tb_capture_snapshot_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cap_en;
    logic [1:0]  src_sel;
    logic [7:0]  cnt_lo, cnt_hi;
    logic [1:0]  tick;
    logic [1:0]  ext_pin;
    logic [15:0] shadow, rd_data;
    logic        cap_irq;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_sh;

    capture_snapshot_unit dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .src_sel (src_sel),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .tick    (tick),
        .ext_pin (ext_pin),
        .shadow  (shadow),
        .rd_data (rd_data),
        .cap_irq (cap_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] read_model(input logic en, input logic [15:0] snap,
                                               input logic [7:0] hi, input logic [7:0] lo);
        return en ? snap : {hi, lo};
    endfunction

    function automatic logic tick_hit(input logic en, input logic [1:0] sel,
                                      input logic [1:0] tk);
        return en && (sel < 2'd2) && tk[sel[0]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        cnt_hi = v[15:8];
        cnt_lo = v[7:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic exp_irq;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; cap_en = 1'b0; src_sel = 2'd0;
        cnt_lo = 8'h5a; cnt_hi = 8'ha5; tick = 2'b00; ext_pin = 2'b00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 shadow", 32'(shadow), 32'h0);
        chk("R1 irq", 32'(cap_irq), 32'h0);
        chk("R2 live read", 32'(rd_data), 32'ha55a);
        rst_n = 1'b1;
        exp_sh = 16'h0;
        step();

        // R5 pin 0: value changes before each of the three edges
        cap_en = 1'b1; src_sel = 2'd2;
        set_cnt(16'h1111); ext_pin[0] = 1'b1;
        step(); chk("R5 no irq edge1", 32'(cap_irq), 32'h0);
        set_cnt(16'h2222);
        step(); chk("R5 no irq edge2", 32'(cap_irq), 32'h0);
        set_cnt(16'h3333);
        step(); chk("R5 irq edge3", 32'(cap_irq), 32'h1);
        chk("R5 shadow edge3", 32'(shadow), 32'h3333);
        exp_sh = 16'h3333;
        set_cnt(16'h4444);
        step(); chk("R6 irq one cycle", 32'(cap_irq), 32'h0);
        for (int i = 0; i < 3; i++) begin
            step(); chk("R5 held level no recapture", 32'(cap_irq), 32'h0);
        end
        chk("R5 shadow held", 32'(shadow), 32'h3333);

        // R4 rising edge on pin 1 while pin 0 is selected
        ext_pin[1] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step(); chk("R4 unselected pin irq", 32'(cap_irq), 32'h0);
        end
        chk("R4 unselected pin shadow", 32'(shadow), 32'h3333);
        chk("R2 shadow read", 32'(rd_data), 32'h3333);

        // R5 pin 1 already high when selected: no edge, no capture
        src_sel = 2'd3;
        for (int i = 0; i < 3; i++) begin
            step(); chk("R5 stale level", 32'(cap_irq), 32'h0);
        end
        ext_pin[1] = 1'b0;
        repeat (3) step();
        set_cnt(16'hbeef); ext_pin[1] = 1'b1;
        step(); step();
        chk("R5 pin1 not yet", 32'(cap_irq), 32'h0);
        step();
        chk("R5 pin1 irq", 32'(cap_irq), 32'h1);
        chk("R5 pin1 shadow", 32'(shadow), 32'hbeef);
        exp_sh = 16'hbeef;

        // R7 disabled: ticks ignored, live read, shadow held
        cap_en = 1'b0; src_sel = 2'd0; tick = 2'b01; set_cnt(16'h0f0f);
        for (int i = 0; i < 3; i++) begin
            step(); chk("R7 disabled irq", 32'(cap_irq), 32'h0);
        end
        chk("R2 disabled live read", 32'(rd_data), 32'h0f0f);
        tick = 2'b00; cap_en = 1'b1;
        #1 chk("R7 shadow kept", 32'(rd_data), 32'hbeef);

        // R7 pin edge that occurs while disabled is lost
        src_sel = 2'd2; ext_pin[0] = 1'b0;
        repeat (3) step();
        cap_en = 1'b0; ext_pin[0] = 1'b1;
        repeat (4) step();
        chk("R7 disabled pin irq", 32'(cap_irq), 32'h0);
        cap_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(); chk("R7 no late capture", 32'(cap_irq), 32'h0);
        end
        chk("R7 shadow after late enable", 32'(shadow), 32'hbeef);
        ext_pin = 2'b00;
        repeat (3) step();

        // R3 R4 R6 R8 random ticks, counters changing every cycle
        for (int n = 0; n < 500; n++) begin
            cap_en  = (($urandom % 8) != 0);
            src_sel = 2'($urandom % 2);
            tick    = 2'($urandom % 4);
            cnt_lo  = 8'($urandom);
            cnt_hi  = 8'($urandom);
            #1 chk("R2 read mux", 32'(rd_data), 32'(read_model(cap_en, exp_sh, cnt_hi, cnt_lo)));
            exp_irq = tick_hit(cap_en, src_sel, tick);
            if (exp_irq) exp_sh = {cnt_hi, cnt_lo};
            step();
            chk("R3 R8 snapshot", 32'(shadow), 32'(exp_sh));
            chk(cap_en ? "R4 R6 irq" : "R7 irq", 32'(cap_irq), 32'(exp_irq));
        end
        tick = 2'b00;
        step();
        chk("R6 irq clears", 32'(cap_irq), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule